// File: doc/BRIEF.md
# Supply Reset Sequencer

This block turns digitised supply-monitor flags into a chip reset and a state-freeze signal. Four asynchronous flags come in from analog monitors: core supply under roughly one volt, core supply back above its release level of about two volts, core supply below a programmed brownout threshold, and analog supply within range. A static configuration bit selects which of two schemes drives the reset. In the default scheme a low-supply dip must persist for a qualification time, counted on a slow timebase strobe, before reset is raised. The reset then stays up until the release flag appears. In the brownout scheme the freeze output stays high for as long as the supply sits below the threshold, and a reset pulse follows when the supply recovers.

Every reset ends with a fixed number of stretch cycles after its release condition, so downstream logic sees one clean pulse. The comparators themselves and the threshold value sit outside the block. It sees them only as input flags and a configuration bit.

Top module: `pwr_rst_seq`

## Requirements
- R1: Each monitor flag passes through two flip-flops before use. With `tick` high on every cycle, the cycles from applying a held low-supply flag to the first cycle of `chip_rst` are QUAL_TICKS+3.
- R2: With `bor_mode` low, `chip_rst` rises only after `vdd_low_a` has stayed high across QUAL_TICKS `tick` strobes. A shorter dip raises no reset. A dip that ends early clears the count, so two short dips do not add up. Cycles without `tick` do not count.
- R3: Once a power-on reset is raised, `chip_rst` stays high until `vdd_rel_a` is seen high. How long the supply took to rise has no effect on this.
- R4: After the synchronised release flag is seen, `chip_rst` stays high for STRETCH_CYC more cycles. Counted from the cycle the release input is applied, it is high for STRETCH_CYC+2 sampled cycles.
- R5: With `bor_mode` high, a low-supply dip of any length raises no reset.
- R6: With `bor_mode` and `avdd_ok_a` high, `hold` is high for as many cycles as the synchronised `bor_low_a` is high.
- R7: When `bor_low_a` clears after a hold, `hold` drops and `chip_rst` is high for exactly STRETCH_CYC cycles.
- R8: While `avdd_ok_a` is low, `bor_low_a` is ignored and gives neither hold nor reset. If `avdd_ok_a` drops during a hold, `hold` is released and no reset follows.
- R9: During and right after `rst_n` low, `chip_rst` is high and `hold` is low. The block leaves this state only through the release path of R3/R4.
- R10: `hold` and `chip_rst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle slow timebase strobe, synchronous to clk |
| bor_mode | input | 1 | Configuration: 1 selects the brownout scheme, 0 the power-on scheme |
| vdd_low_a | input | 1 | Async: core supply under the power-on trip level |
| vdd_rel_a | input | 1 | Async: core supply above the power-on release level |
| bor_low_a | input | 1 | Async: core supply below the brownout threshold |
| avdd_ok_a | input | 1 | Async: analog supply within its operating range |
| chip_rst | output | 1 | Chip reset, active high |
| hold | output | 1 | Freeze device state, active high |

## Verification
The assertions take three things for granted. `bor_mode` changes only while no reset or hold is in progress. `vdd_low_a` and `vdd_rel_a` are never high together. `tick` is a single-cycle strobe in the clock domain. The stimulus follows these rules: it changes `bor_mode` only after every pulse has finished, it drops the release flag before each new dip, and it drives `tick` either constantly high or constantly low. This keeps dip lengths in whole ticks and lets the expected results be worked out by arithmetic.

// File: rtl/pwr_rst_pkg.sv
// Package: shared types for the supply reset sequencer.
// Assumes: nothing; holds only the sequencer state encoding.
package pwr_rst_pkg;

    // Sequencer states: idle, power-on reset waiting for release,
    // brownout freeze, and reset stretch.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_STRETCH = 2'd3
    } prs_state_t;

endpackage

// File: rtl/pwr_sync.sv
// Module: pwr_sync
// Brings W asynchronous single-bit flags into the clk domain through a
// two-stage flip-flop chain per bit.
// Assumes: each flag is level-like and stable for several clk cycles;
// multi-bit coherence between flags is not needed.
module pwr_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_a,
    output logic [W-1:0] q_s
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic sync_q;

        // Two-stage capture of flag bit i; clears under reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_a[i];
                sync_q <= meta_q;
            end
        end

        assign q_s[i] = sync_q;
    end

endmodule

// File: rtl/pwr_qual_timer.sv
// Module: pwr_qual_timer
// Measures how long the core supply has stayed low. It counts tick strobes
// while run is high, clears when run drops, and saturates at QUAL_TICKS,
// where expired is raised.
// Assumes: tick is a one-cycle strobe in the clk domain; run is synchronous.
module pwr_qual_timer #(
    parameter int QUAL_TICKS = 200,
    parameter int QCW        = $clog2(QUAL_TICKS + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           run,
    output logic [QCW-1:0] cnt,
    output logic           expired
);

    localparam logic [QCW-1:0] LIMIT = QCW'(QUAL_TICKS);

    logic [QCW-1:0] cnt_q;

    // Qualification count: clear on a gap, advance on tick, stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q != LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt     = cnt_q;
    assign expired = (cnt_q == LIMIT);

endmodule

// File: rtl/pwr_rst_fsm.sv
// Module: pwr_rst_fsm
// Sequencer core. Picks the power-on or brownout scheme from bor_mode,
// drives chip_rst and hold, and times the reset stretch.
// Assumes: all flags are already synchronised; bor_mode is quasi-static.
module pwr_rst_fsm
    import pwr_rst_pkg::*;
#(
    parameter int STRETCH_CYC = 16,
    parameter int SCW         = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bor_mode,
    input  logic           qual_expired,
    input  logic           rel_s,
    input  logic           bor_s,
    input  logic           avok_s,
    output prs_state_t     state,
    output logic [SCW-1:0] scnt,
    output logic           chip_rst,
    output logic           hold
);

    localparam logic [SCW-1:0] SLOAD = SCW'(STRETCH_CYC - 1);

    prs_state_t     st_q, st_d;
    logic [SCW-1:0] sc_q, sc_d;
    logic           bor_live;

    // Brownout comparator is trusted only in brownout mode with analog supply valid.
    assign bor_live = bor_mode && avok_s;

    // Next-state and stretch-count decision.
    always_comb begin
        st_d = st_q;
        sc_d = sc_q;
        unique case (st_q)
            ST_IDLE: begin
                if (bor_live && bor_s) begin
                    st_d = ST_HOLD;
                end else if (!bor_mode && qual_expired) begin
                    st_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (rel_s) begin
                    st_d = ST_STRETCH;
                    sc_d = SLOAD;
                end
            end
            ST_HOLD: begin
                if (!bor_live) begin
                    st_d = ST_IDLE;
                end else if (!bor_s) begin
                    st_d = ST_STRETCH;
                    sc_d = SLOAD;
                end
            end
            ST_STRETCH: begin
                if (sc_q == '0) begin
                    st_d = ST_IDLE;
                end else begin
                    sc_d = sc_q - 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State register: reset behaves like power-up and waits for release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_ARMED;
            sc_q <= '0;
        end else begin
            st_q <= st_d;
            sc_q <= sc_d;
        end
    end

    assign state    = st_q;
    assign scnt     = sc_q;
    assign chip_rst = (st_q == ST_ARMED) || (st_q == ST_STRETCH);
    assign hold     = (st_q == ST_HOLD);

endmodule

// File: rtl/pwr_rst_seq.sv
// Module: pwr_rst_seq (top)
// Supply reset sequencer. It synchronises the monitor flags, qualifies
// low-supply dips on the slow tick and sequences the reset or freeze.
// Assumes: tick is a clk-domain strobe; bor_mode changes only when idle;
// vdd_low_a and vdd_rel_a are never high together.
module pwr_rst_seq
    import pwr_rst_pkg::*;
#(
    parameter int QUAL_TICKS  = 200,
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bor_mode,
    input  logic vdd_low_a,
    input  logic vdd_rel_a,
    input  logic bor_low_a,
    input  logic avdd_ok_a,
    output logic chip_rst,
    output logic hold
);

    localparam int NFLAG = 4;
    localparam int QCW   = $clog2(QUAL_TICKS + 1);
    localparam int SCW   = (STRETCH_CYC > 1) ? $clog2(STRETCH_CYC) : 1;

    logic [NFLAG-1:0] flags_s;
    logic             low_s, rel_s, bor_s, avok_s;
    logic [QCW-1:0]   qcnt;
    logic             qexp;
    logic [SCW-1:0]   scnt;
    prs_state_t       state;

    pwr_sync #(.W(NFLAG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_a   ({avdd_ok_a, bor_low_a, vdd_rel_a, vdd_low_a}),
        .q_s   (flags_s)
    );

    assign low_s  = flags_s[0];
    assign rel_s  = flags_s[1];
    assign bor_s  = flags_s[2];
    assign avok_s = flags_s[3];

    // The power-on path is switched off entirely in brownout mode.
    pwr_qual_timer #(.QUAL_TICKS(QUAL_TICKS), .QCW(QCW)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (low_s && !bor_mode),
        .cnt     (qcnt),
        .expired (qexp)
    );

    pwr_rst_fsm #(.STRETCH_CYC(STRETCH_CYC), .SCW(SCW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .bor_mode     (bor_mode),
        .qual_expired (qexp),
        .rel_s        (rel_s),
        .bor_s        (bor_s),
        .avok_s       (avok_s),
        .state        (state),
        .scnt         (scnt),
        .chip_rst     (chip_rst),
        .hold         (hold)
    );

endmodule

// File: rtl/pwr_rst_seq_chk.sv
// Module: pwr_rst_seq_chk
// Assertion checker bound into pwr_rst_seq. It watches the synchronised
// flags, the qualification count, the state and the outputs.
// Assumes: bor_mode is quasi-static, as the top module expects.
module pwr_rst_seq_chk
    import pwr_rst_pkg::*;
#(
    parameter int QUAL_TICKS  = 200,
    parameter int STRETCH_CYC = 16,
    parameter int QCW         = 8,
    parameter int SCW         = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bor_mode,
    input logic           low_s,
    input logic           bor_s,
    input logic           avok_s,
    input logic [QCW-1:0] qcnt,
    input logic [SCW-1:0] scnt,
    input prs_state_t     state,
    input logic           chip_rst,
    input logic           hold
);

    // R2: a gap in the low flag clears the qualification count
    a_r2_gap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!low_s) |-> (qcnt == '0));

    // R2 / R5: power-on reset is entered only from an expired count in power-on mode
    a_r2_arm_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && $past(state) != ST_ARMED)
            |-> $past(qcnt == QCW'(QUAL_TICKS) && !bor_mode));

    // R4 / R7: reset drops only at the end of a complete stretch
    a_r4_stretch_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst) |-> $past(state == ST_STRETCH && scnt == '0));

    // R6 / R8: hold needs brownout mode, valid analog supply and a low comparator
    a_r6_hold_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> $past(bor_mode && avok_s && bor_s));

    // R7 / R8: leaving hold gives reset exactly when the comparator was still trusted
    a_r8_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |-> (chip_rst == $past(bor_mode && avok_s)));

    // R10: freeze and reset never overlap
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold && chip_rst));

endmodule

bind pwr_rst_seq pwr_rst_seq_chk #(
    .QUAL_TICKS  (QUAL_TICKS),
    .STRETCH_CYC (STRETCH_CYC),
    .QCW         (QCW),
    .SCW         (SCW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bor_mode (bor_mode),
    .low_s    (low_s),
    .bor_s    (bor_s),
    .avok_s   (avok_s),
    .qcnt     (qcnt),
    .scnt     (scnt),
    .state    (state),
    .chip_rst (chip_rst),
    .hold     (hold)
);

// File: tb/pwr_rst_seq_tb.sv
module pwr_rst_seq_tb;

    localparam int Q = 4;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n, tick, bor_mode, vdd_low_a, vdd_rel_a, bor_low_a, avdd_ok_a;
    logic chip_rst, hold;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_rst_seq #(.QUAL_TICKS(Q), .STRETCH_CYC(S)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bor_mode  (bor_mode),
        .vdd_low_a (vdd_low_a),
        .vdd_rel_a (vdd_rel_a),
        .bor_low_a (bor_low_a),
        .avdd_ok_a (avdd_ok_a),
        .chip_rst  (chip_rst),
        .hold      (hold)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Raise release and count sampled reset-high cycles until it drops.
    task automatic release_count(output int cnt);
        cnt = 0;
        vdd_rel_a = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (chip_rst) cnt++;
            else break;
        end
        vdd_rel_a = 1'b0;
        wait_n(4);
    endtask

    // Apply a low-supply dip of len cycles.
    task automatic low_dip(input int len);
        vdd_low_a = 1'b1;
        wait_n(len);
        vdd_low_a = 1'b0;
    endtask

    initial begin
        int cnt, hcnt, rcnt, first;
        rst_n = 1'b0; tick = 1'b1; bor_mode = 1'b0; vdd_low_a = 1'b0;
        vdd_rel_a = 1'b0; bor_low_a = 1'b0; avdd_ok_a = 1'b1;
        wait_n(3);
        chk("R9 chip_rst in reset", chip_rst, 1);
        chk("R9 hold in reset", hold, 0);
        rst_n = 1'b1;
        wait_n(6);
        chk("R9 chip_rst held after reset", chip_rst, 1);
        chk("R3 no release without flag", chip_rst, 1);
        release_count(cnt);
        chk("R4 stretch after reset release", cnt, S + 2);

        // R2: sweep of dip lengths
        for (int len = 1; len <= Q + 2; len++) begin
            low_dip(len);
            wait_n(6);
            chk($sformatf("R2 dip len %0d", len), chip_rst, (len >= Q) ? 1 : 0);
            if (chip_rst) begin
                wait_n(10);
                chk("R3 reset held until release", chip_rst, 1);
                release_count(cnt);
                chk("R4 stretch length", cnt, S + 2);
            end
            wait_n(2);
        end

        // R2: two short dips with a one-cycle gap do not add up
        low_dip(Q - 1);
        wait_n(1);
        low_dip(Q - 1);
        wait_n(6);
        chk("R2 split dips", chip_rst, 0);

        // R2: no tick, no count
        tick = 1'b0;
        low_dip(3 * Q);
        wait_n(6);
        chk("R2 no tick no reset", chip_rst, 0);
        tick = 1'b1;

        // R1: latency of two sync stages, the count and the state register
        vdd_low_a = 1'b1;
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (chip_rst) begin first = k; break; end
        end
        vdd_low_a = 1'b0;
        chk("R1 trip latency", first, Q + 3);
        wait_n(3);
        release_count(cnt);

        // R5: brownout mode disables the power-on path
        bor_mode = 1'b1;
        low_dip(4 * Q);
        wait_n(6);
        chk("R5 no power-on reset in brownout mode", chip_rst, 0);

        // R6 / R7 / R10: sweep of brownout widths
        for (int w = 1; w <= 5; w++) begin
            hcnt = 0; rcnt = 0;
            bor_low_a = 1'b1;
            for (int k = 0; k < w + S + 8; k++) begin
                if (k == w) bor_low_a = 1'b0;
                @(negedge clk);
                if (hold) hcnt++;
                if (chip_rst) rcnt++;
                if (hold && chip_rst) chk("R10 overlap", 1, 0);
            end
            chk($sformatf("R6 hold cycles w=%0d", w), hcnt, w);
            chk($sformatf("R7 reset cycles w=%0d", w), rcnt, S);
        end

        // R8: analog supply invalid, comparator ignored
        avdd_ok_a = 1'b0;
        wait_n(4);
        hcnt = 0; rcnt = 0;
        bor_low_a = 1'b1;
        for (int k = 0; k < 12; k++) begin
            if (k == 5) bor_low_a = 1'b0;
            @(negedge clk);
            if (hold) hcnt++;
            if (chip_rst) rcnt++;
        end
        chk("R8 no hold when analog invalid", hcnt, 0);
        chk("R8 no reset when analog invalid", rcnt, 0);

        // R8: analog supply lost during hold
        avdd_ok_a = 1'b1;
        wait_n(4);
        bor_low_a = 1'b1;
        wait_n(5);
        chk("R6 hold while low", hold, 1);
        avdd_ok_a = 1'b0;
        rcnt = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (chip_rst) rcnt++;
        end
        chk("R8 hold released", hold, 0);
        chk("R8 no reset after lost analog", rcnt, 0);
        bor_low_a = 1'b0;
        wait_n(6);
        chk("R8 still no reset", chip_rst, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule